// File: doc/BRIEF.md
# Edge-Pulse Isolation Channel Codec

This block carries one digital level across a modelled isolation barrier. It does not send the level itself. The sending half turns each rising edge of its input into a short pulse on a "set" line and each falling edge into a short pulse on a "clear" line. While the input holds still, the sender repeats the present level at a fixed interval with a refresh pulse on the matching line.

The receiving half is a bistable latch. A pulse on the set line drives its output high. A pulse on the clear line drives it low. Without pulses the output holds its value. A watchdog in the receiver counts cycles without pulses. When the count reaches its limit, the receiver assumes the sender is dead, forces a parameter-chosen default level and raises a fault flag. The next valid pulse ends the fault.

The two halves meet only at the pulse lines, which are separate ports. The surrounding logic, or a bench, connects the encoder outputs to the decoder inputs, with or without corruption. All timing is counted in clock cycles: pulse width `PULSE_W`, refresh gap `REFRESH_CYC` and watchdog limit `TIMEOUT_CYC`. `TIMEOUT_CYC` must exceed `PULSE_W + REFRESH_CYC`.

Top module: `edge_pulse_iso_codec`

## Requirements
- R1: While `rst_n` is low, `tx_set`, `tx_clr` and `proto_err` are 0, `dout` equals `DEFAULT_LVL` and `fault` is 1.
- R2: When `din` is sampled at 1 after being 0, `tx_set` is high (and `tx_clr` low) for exactly `PULSE_W` cycles, starting at the next clock edge.
- R3: When `din` is sampled at 0 after being 1, `tx_clr` is high (and `tx_set` low) for exactly `PULSE_W` cycles, starting at the next clock edge.
- R4: With `din` static, exactly `REFRESH_CYC` low cycles separate the end of one pulse from the next. The next pulse is a refresh pulse on the line that matches `din` (`tx_set` for 1, `tx_clr` for 0).
- R5: An input edge takes priority over a pending refresh, including in the cycle the refresh would start. The refresh gap restarts from the end of every pulse sent.
- R6: `rx_set` alone drives `dout` to 1 at the next edge, and `rx_clr` alone drives it to 0. With neither line high and no timeout, `dout` holds its value.
- R7: After `TIMEOUT_CYC` consecutive clock edges with no valid pulse sampled, `dout` becomes `DEFAULT_LVL` and `fault` becomes 1. One edge earlier, both are still unchanged.
- R8: A valid pulse (exactly one of `rx_set` or `rx_clr` high) clears `fault` and restarts the watchdog at the next edge. `dout` takes the level the pulse indicates.
- R9: `rx_set` and `rx_clr` high in the same cycle raise `proto_err` for the next cycle. `dout` and `fault` do not change, and the conflict does not count as a valid pulse.
- R10: With the pulse lines looped back, `dout` follows `din` two edges after `din` is sampled. With `din` static, `fault` stays low indefinitely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | 1 | Level to carry across the barrier |
| tx_set | output | 1 | Encoder set-pulse line |
| tx_clr | output | 1 | Encoder clear-pulse line |
| rx_set | input | 1 | Decoder set-pulse line from the barrier |
| rx_clr | input | 1 | Decoder clear-pulse line from the barrier |
| dout | output | 1 | Decoded level |
| fault | output | 1 | High while the output is forced by the watchdog |
| proto_err | output | 1 | High for one cycle after set and clear arrived together |

## Verification
The encoder is driven with single rising and falling edges, with a long static level, and with edges placed both midway through a refresh countdown and exactly on the cycle a refresh would start. Together these separate edge pulses from refresh pulses and show that the countdown restarts after each pulse. The decoder is isolated from the encoder and fed injected set, clear, idle and conflicting pulses, both from the faulted state and from a live state. This shows which stimulus moves the latch and at which cycle the watchdog fires. A closed-loop run with toggling and then static input confirms that refresh keeps the watchdog from ever expiring.

// File: rtl/edge_pulse_iso_codec.sv
module edge_pulse_iso_codec #(
  parameter int PULSE_W     = 3,
  parameter int REFRESH_CYC = 50,
  parameter int TIMEOUT_CYC = 200,
  parameter bit DEFAULT_LVL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic tx_set,
  output logic tx_clr,
  input  logic rx_set,
  input  logic rx_clr,
  output logic dout,
  output logic fault,
  output logic proto_err
);
  localparam int PW = $clog2(PULSE_W + 1);
  localparam int RW = (REFRESH_CYC > 2) ? $clog2(REFRESH_CYC) : 1;
  localparam int TW = (TIMEOUT_CYC > 2) ? $clog2(TIMEOUT_CYC) : 1;
  localparam logic [PW-1:0] P_LEN  = PW'(PULSE_W);
  localparam logic [RW-1:0] R_LAST = RW'(REFRESH_CYC - 1);
  localparam logic [TW-1:0] T_LAST = TW'(TIMEOUT_CYC - 1);

  logic          din_q, pol;
  logic [PW-1:0] pcnt;
  logic [RW-1:0] rcnt;
  logic [TW-1:0] wcnt;

  wire edge_seen = din ^ din_q;
  wire busy      = pcnt != '0;
  wire conflict  = rx_set & rx_clr;
  wire valid     = rx_set ^ rx_clr;

  assign tx_set = busy & pol;
  assign tx_clr = busy & ~pol;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      din_q <= 1'b0;
      pol   <= 1'b0;
      pcnt  <= '0;
      rcnt  <= '0;
    end else begin
      din_q <= din;
      if (edge_seen) begin
        pcnt <= P_LEN;
        pol  <= din;
        rcnt <= '0;
      end else if (busy) begin
        pcnt <= pcnt - 1'b1;
        rcnt <= '0;
      end else if (rcnt == R_LAST) begin
        pcnt <= P_LEN;
        pol  <= din_q;
        rcnt <= '0;
      end else begin
        rcnt <= rcnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout      <= DEFAULT_LVL;
      fault     <= 1'b1;
      wcnt      <= '0;
      proto_err <= 1'b0;
    end else begin
      proto_err <= conflict;
      if (valid) begin
        dout  <= rx_set;
        fault <= 1'b0;
        wcnt  <= '0;
      end else if (wcnt == T_LAST && !conflict) begin
        dout  <= DEFAULT_LVL;
        fault <= 1'b1;
      end else if (wcnt != T_LAST) begin
        wcnt <= wcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/edge_pulse_iso_codec_chk.sv
module edge_pulse_iso_codec_chk (
  input logic clk,
  input logic rst_n,
  input logic din,
  input logic tx_set,
  input logic tx_clr,
  input logic rx_set,
  input logic rx_clr,
  input logic dout,
  input logic fault,
  input logic proto_err
);
  logic started;
  always_ff @(posedge clk) started <= rst_n;

  // R2 / R3: a sampled input edge opens a pulse of matching polarity
  a_r2_edge_opens_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (started && din != $past(din)) |=> (tx_set == $past(din) && tx_clr == !$past(din)));

  // R6: lone set or clear moves the latch
  a_r6_set_drives_high: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_set && !rx_clr) |=> dout);
  a_r6_clr_drives_low: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_clr && !rx_set) |=> !dout);

  // R6 / R7: output moves only on a pulse or a watchdog expiry
  a_r7_change_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    started && !$stable(dout) |-> ($past(rx_set ^ rx_clr) || $rose(fault)));

  // R8: valid pulse clears the fault
  a_r8_pulse_clears_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_set ^ rx_clr) |=> !fault);

  // R9: conflict flagged, state held
  a_r9_conflict_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_set && rx_clr) |=> (proto_err && $stable(dout) && $stable(fault)));

  // R2 / R3: lines never both high
  a_r3_lines_apart: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({tx_set, tx_clr}) <= 1);
endmodule

bind edge_pulse_iso_codec edge_pulse_iso_codec_chk chk_i (
  .clk(clk), .rst_n(rst_n), .din(din), .tx_set(tx_set), .tx_clr(tx_clr),
  .rx_set(rx_set), .rx_clr(rx_clr), .dout(dout), .fault(fault),
  .proto_err(proto_err)
);

// File: tb/edge_pulse_iso_codec_tb_top.sv
`timescale 1ns/1ps
module edge_pulse_iso_codec_tb_top;
  localparam int W = 3;
  localparam int R = 50;
  localparam int T = 200;
  localparam bit DEF = 1'b0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic din = 1'b0;
  logic loop_en = 1'b0;
  logic inj_set = 1'b0;
  logic inj_clr = 1'b0;
  logic tx_set, tx_clr, dout, fault, proto_err;
  logic rx_set, rx_clr;
  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  assign rx_set = loop_en ? tx_set : inj_set;
  assign rx_clr = loop_en ? tx_clr : inj_clr;

  edge_pulse_iso_codec #(.PULSE_W(W), .REFRESH_CYC(R), .TIMEOUT_CYC(T), .DEFAULT_LVL(DEF)) dut_i (
    .clk(clk), .rst_n(rst_n), .din(din), .tx_set(tx_set), .tx_clr(tx_clr),
    .rx_set(rx_set), .rx_clr(rx_clr), .dout(dout), .fault(fault), .proto_err(proto_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic nx();
    @(negedge clk);
  endtask

  task automatic gap(output int lows, output bit s, output bit c);
    while (tx_set || tx_clr) nx();
    lows = 0;
    while (!(tx_set || tx_clr) && lows < R + 10) begin
      lows++;
      nx();
    end
    s = tx_set;
    c = tx_clr;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (4) nx();
    chk(!tx_set && !tx_clr && !proto_err, "R1 lines", {tx_set, tx_clr, proto_err}, 0);
    chk(dout == DEF && fault, "R1 out", {dout, fault}, {DEF, 1'b1});
    rst_n = 1'b1;
    nx();
  endtask

  task automatic t_edge(input bit lvl, input string req);
    din = lvl;
    for (int i = 0; i < W; i++) begin
      nx();
      chk(tx_set == lvl && tx_clr == !lvl, req, {tx_set, tx_clr}, {lvl, !lvl});
    end
    nx();
    chk(!tx_set && !tx_clr, {req, " end"}, {tx_set, tx_clr}, 0);
  endtask

  task automatic t_refresh();
    int n; bit s, c;
    gap(n, s, c);
    chk(n == R && c && !s, "R4 clr refresh", n, R);
    t_edge(1'b1, "R2 rise again");
    gap(n, s, c);
    chk(n == R && s && !c, "R4 set refresh", n, R);
  endtask

  task automatic t_priority();
    int n; bit s, c;
    while (tx_set || tx_clr) nx();
    n = 1;
    while (n < R) begin nx(); n++; end
    din = 1'b0;
    nx();
    chk(tx_clr && !tx_set, "R5 edge beats refresh", {tx_set, tx_clr}, 1);
    gap(n, s, c);
    chk(n == R && c, "R5 gap restarts", n, R);
    while (tx_set || tx_clr) nx();
    repeat (R / 2) nx();
    din = 1'b1;
    nx();
    chk(tx_set && !tx_clr, "R5 mid countdown edge", {tx_set, tx_clr}, 2);
    gap(n, s, c);
    chk(n == R && s, "R5 gap after edge pulse", n, R);
  endtask

  task automatic pulse(input bit s, input bit c);
    inj_set = s; inj_clr = c;
    nx();
    inj_set = 1'b0; inj_clr = 1'b0;
  endtask

  task automatic t_decode();
    bit held = 1'b1;
    chk(fault && dout == DEF, "R7 isolated decoder faulted", fault, 1);
    pulse(1'b1, 1'b0);
    chk(dout && !fault, "R6 set / R8 clears fault", {dout, fault}, 2);
    pulse(1'b0, 1'b1);
    chk(!dout, "R6 clear", dout, 0);
    for (int i = 0; i < 20; i++) begin nx(); if (dout) held = 1'b0; end
    chk(held, "R6 hold low", dout, 0);
    pulse(1'b1, 1'b0);
    held = 1'b1;
    for (int i = 0; i < 20; i++) begin nx(); if (!dout) held = 1'b0; end
    chk(held, "R6 hold high", dout, 1);
  endtask

  task automatic t_watchdog();
    pulse(1'b1, 1'b0);
    repeat (T - 1) nx();
    chk(dout && !fault, "R7 one edge early", {dout, fault}, 2);
    nx();
    chk(dout == DEF && fault, "R7 expiry", {dout, fault}, {DEF, 1'b1});
    pulse(1'b1, 1'b0);
    chk(dout && !fault, "R8 recover", {dout, fault}, 2);
  endtask

  task automatic t_conflict();
    pulse(1'b1, 1'b1);
    chk(proto_err && dout && !fault, "R9 live conflict", {proto_err, dout, fault}, 6);
    nx();
    chk(!proto_err, "R9 flag one cycle", proto_err, 0);
    repeat (T + 2) nx();
    chk(fault && dout == DEF, "R9 setup fault", fault, 1);
    pulse(1'b1, 1'b1);
    chk(proto_err && fault && dout == DEF, "R9 conflict no recovery", {proto_err, fault}, 3);
  endtask

  task automatic t_loop();
    bit ok = 1'b1;
    loop_en = 1'b1;
    for (int k = 0; k < 4; k++) begin
      din = ~din;
      nx();
      nx();
      chk(dout == din && !fault, "R10 follow", dout, din);
      repeat (7) nx();
    end
    for (int i = 0; i < 3 * T; i++) begin
      nx();
      if (fault || dout != din) ok = 1'b0;
    end
    chk(ok, "R10 static no fault", fault, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    nx();
    t_reset();
    t_edge(1'b1, "R2 rise");
    t_edge(1'b0, "R3 fall");
    t_refresh();
    t_priority();
    t_decode();
    t_watchdog();
    t_conflict();
    t_loop();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule